// File: doc/BRIEF.md
# Selectable Signed Frequency Offset Unit

This block corrects a measured frequency by a signed offset before the value goes to a readout. It keeps sixteen offset slots. Each slot holds a sign and eight decimal digits, and its resolution is 10 Hz. Four active-low select inputs pick the slot. Each time a new measurement is strobed in, the block adds the chosen offset to the measurement, or subtracts it, and registers the corrected value. A result that would go below zero is clamped to zero. A result that would pass the top of the output range is clamped to the largest value.

Offsets are entered with two debounced single-cycle button pulses, called advance and step. In normal operation, an advance pulse starts setup mode. In setup mode the user first picks the sign. The user then sets seven decimal digits, most significant first. The units-of-Hz digit is fixed at zero and cannot be edited. The block reports which field is being edited and its current value, so that an external display can render it. When the last digit is confirmed, the offset is stored in the slot that was selected when setup began. The slot storage stands in for nonvolatile memory. Results are frozen while setup mode is active.

Top module: `freq_offset_unit`

## Requirements
- R1: After reset, setup_active, freq_out_valid and freq_out are 0, and every slot holds +0, so a measurement passes through unchanged.
- R2: The slot index is the bitwise inverse of sel_n: sel_n = 4'b1111 selects slot 0, and sel_n = 4'b0000 selects slot 15.
- R3: In normal operation, an enter_pulse sets setup_active in the next cycle, with edit_pos = 0 (the sign field) and edit_value = 0 (plus). The slot selected in that cycle becomes the target slot, and editing always starts from +0.
- R4: In the sign field, each scroll_pulse toggles edit_value between 0 (plus) and 1 (minus). An enter_pulse then moves to edit_pos = 1 with edit_value = 0.
- R5: In digit fields (edit_pos 1 to 7, where field k carries weight 10^(8-k) Hz), each scroll_pulse raises edit_value by one from 0 to 9, and 9 wraps to 0. An enter_pulse confirms the digit and moves to the next field with value 0.
- R6: An enter_pulse at edit_pos = 7 stores the sign and digits into the target slot, with a units digit of 0, and clears setup_active in the next cycle. Changes on sel_n during setup do not change the target slot.
- R7: In normal operation, a freq_valid strobe makes freq_out equal freq_in plus or minus the offset of the slot selected in that cycle, and pulses freq_out_valid for one cycle, both in the next cycle.
- R8: A corrected value below 0 is output as 0. A corrected value above 2^FREQ_W-1 is output as 2^FREQ_W-1.
- R9: While setup_active is 1, freq_valid is ignored: freq_out_valid stays 0 and freq_out keeps its value.
- R10: When enter_pulse and scroll_pulse arrive in the same cycle, only the enter_pulse acts. A scroll_pulse in normal operation has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enter_pulse | input | 1 | Debounced advance/confirm button pulse |
| scroll_pulse | input | 1 | Debounced step button pulse |
| sel_n | input | SEL_W | Active-low slot select |
| freq_in | input | FREQ_W | Measured frequency in Hz |
| freq_valid | input | 1 | Measurement strobe |
| freq_out | output | FREQ_W | Corrected frequency in Hz |
| freq_out_valid | output | 1 | Corrected value updated this cycle |
| setup_active | output | 1 | Setup mode flag |
| edit_pos | output | 3 | Field being edited: 0 sign, 1..7 digits |
| edit_value | output | 4 | Current sign (0/1) or digit (0..9) |

## Verification
Offsets are applied with a positive offset on a mid-range slot, a large negative offset that both reduces a reading and clamps another to zero, and a near-full-scale positive offset that saturates. Reading the unprogrammed slot between them tells a slot decode fault apart from an apply fault. The entry patterns step digits past 9 to expose wrap errors, toggle the sign an odd number of times, press both buttons together, and move the select lines during setup, which separates a slot latched at entry from one sampled at write time. A behavioural model compares every output on every cycle.

// File: rtl/fou_pkg.sv
package fou_pkg;
    localparam int OFS_DIGITS = 8;
    localparam int BCD_W      = 4 * OFS_DIGITS;
    localparam int POS_W      = $clog2(OFS_DIGITS);
    localparam int LAST_POS   = OFS_DIGITS - 1;
    localparam int OFS_HZ_W   = 27;

    typedef enum logic [1:0] {
        ENT_IDLE  = 2'd0,
        ENT_SIGN  = 2'd1,
        ENT_DIGIT = 2'd2
    } entry_state_t;

    typedef struct packed {
        logic             neg;
        logic [BCD_W-1:0] bcd;
    } offset_t;

    // Decimal digit lanes to a binary Hz value, most significant lane first.
    function automatic logic [OFS_HZ_W-1:0] bcd_to_hz(input logic [BCD_W-1:0] bcd);
        logic [OFS_HZ_W-1:0] acc;
        acc = '0;
        for (int i = OFS_DIGITS - 1; i >= 0; i--) begin
            acc = acc * OFS_HZ_W'(10) + OFS_HZ_W'(bcd[4*i +: 4]);
        end
        return acc;
    endfunction

    function automatic logic [3:0] digit_step(input logic [3:0] d);
        return (d >= 4'd9) ? 4'd0 : d + 4'd1;
    endfunction
endpackage

// File: rtl/fou_entry_fsm.sv
module fou_entry_fsm
    import fou_pkg::*;
#(
    parameter int SEL_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             enter_pulse,
    input  logic             scroll_pulse,
    input  logic [SEL_W-1:0] cur_slot,
    output logic             wr_en,
    output logic [SEL_W-1:0] wr_slot,
    output offset_t          wr_data,
    output logic             setup_active,
    output logic [POS_W-1:0] edit_pos,
    output logic [3:0]       edit_value
);
    entry_state_t     state_q;
    logic [POS_W-1:0] pos_q;
    logic             sign_q;
    logic [3:0]       digit_q;
    logic [BCD_W-1:0] work_q;
    logic [SEL_W-1:0] slot_q;
    logic [BCD_W-1:0] bcd_ins;
    logic             last_field;

    assign last_field = (pos_q == POS_W'(LAST_POS));

    // Working digits with the digit under edit placed in its lane.
    always_comb begin
        bcd_ins = work_q;
        for (int l = 1; l < OFS_DIGITS; l++) begin
            if (pos_q == POS_W'(OFS_DIGITS - l)) begin
                bcd_ins[4*l +: 4] = digit_q;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ENT_IDLE;
            pos_q   <= '0;
            sign_q  <= 1'b0;
            digit_q <= '0;
            work_q  <= '0;
            slot_q  <= '0;
        end else begin
            unique case (state_q)
                ENT_IDLE: begin
                    if (enter_pulse) begin
                        state_q <= ENT_SIGN;
                        pos_q   <= '0;
                        sign_q  <= 1'b0;
                        digit_q <= '0;
                        work_q  <= '0;
                        slot_q  <= cur_slot;
                    end
                end
                ENT_SIGN: begin
                    if (enter_pulse) begin
                        state_q <= ENT_DIGIT;
                        pos_q   <= POS_W'(1);
                        digit_q <= '0;
                    end else if (scroll_pulse) begin
                        sign_q <= ~sign_q;
                    end
                end
                ENT_DIGIT: begin
                    if (enter_pulse) begin
                        work_q  <= bcd_ins;
                        digit_q <= '0;
                        if (last_field) begin
                            state_q <= ENT_IDLE;
                            pos_q   <= '0;
                        end else begin
                            pos_q <= pos_q + POS_W'(1);
                        end
                    end else if (scroll_pulse) begin
                        digit_q <= digit_step(digit_q);
                    end
                end
                default: state_q <= ENT_IDLE;
            endcase
        end
    end

    assign wr_en        = (state_q == ENT_DIGIT) && enter_pulse && last_field;
    assign wr_slot      = slot_q;
    assign wr_data.neg  = sign_q;
    assign wr_data.bcd  = bcd_ins;
    assign setup_active = (state_q != ENT_IDLE);
    assign edit_pos     = pos_q;

    always_comb begin
        unique case (state_q)
            ENT_SIGN:  edit_value = {3'b000, sign_q};
            ENT_DIGIT: edit_value = digit_q;
            default:   edit_value = 4'd0;
        endcase
    end
endmodule

// File: rtl/fou_slot_store.sv
module fou_slot_store
    import fou_pkg::*;
#(
    parameter int SEL_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [SEL_W-1:0] wr_slot,
    input  offset_t          wr_data,
    input  logic [SEL_W-1:0] rd_slot,
    output offset_t          rd_data
);
    localparam int NUM_SLOTS = 1 << SEL_W;

    offset_t slots [NUM_SLOTS];

    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst) begin
                slots[s] <= '0;
            end else if (wr_en && (wr_slot == SEL_W'(s))) begin
                slots[s] <= wr_data;
            end
        end
    end

    assign rd_data = slots[rd_slot];
endmodule

// File: rtl/fou_apply.sv
module fou_apply
    import fou_pkg::*;
#(
    parameter int FREQ_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              hold,
    input  logic              freq_valid,
    input  logic [FREQ_W-1:0] freq_in,
    input  offset_t           offset,
    output logic [FREQ_W-1:0] freq_out,
    output logic              freq_out_valid
);
    localparam int EXT_W = FREQ_W + 1;

    logic [OFS_HZ_W-1:0] ofs_hz;
    logic [EXT_W-1:0]    ofs_ext;
    logic [EXT_W-1:0]    sum_ext;
    logic [EXT_W-1:0]    dif_ext;
    logic [FREQ_W-1:0]   result;

    assign ofs_hz  = bcd_to_hz(offset.bcd);
    assign ofs_ext = {{(EXT_W - OFS_HZ_W){1'b0}}, ofs_hz};
    assign sum_ext = {1'b0, freq_in} + ofs_ext;
    assign dif_ext = {1'b0, freq_in} - ofs_ext;

    always_comb begin
        if (offset.neg) begin
            result = dif_ext[FREQ_W] ? '0 : dif_ext[FREQ_W-1:0];
        end else begin
            result = sum_ext[FREQ_W] ? '1 : sum_ext[FREQ_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            freq_out       <= '0;
            freq_out_valid <= 1'b0;
        end else begin
            freq_out_valid <= freq_valid && !hold;
            if (freq_valid && !hold) begin
                freq_out <= result;
            end
        end
    end
endmodule

// File: rtl/freq_offset_unit.sv
module freq_offset_unit
    import fou_pkg::*;
#(
    parameter int FREQ_W = 32,
    parameter int SEL_W  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              enter_pulse,
    input  logic              scroll_pulse,
    input  logic [SEL_W-1:0]  sel_n,
    input  logic [FREQ_W-1:0] freq_in,
    input  logic              freq_valid,
    output logic [FREQ_W-1:0] freq_out,
    output logic              freq_out_valid,
    output logic              setup_active,
    output logic [POS_W-1:0]  edit_pos,
    output logic [3:0]        edit_value
);
    logic [SEL_W-1:0] cur_slot;
    logic             wr_en;
    logic [SEL_W-1:0] wr_slot;
    offset_t          wr_data;
    offset_t          rd_data;

    assign cur_slot = ~sel_n;

    fou_entry_fsm #(.SEL_W(SEL_W)) u_fsm (
        .clk          (clk),
        .rst          (rst),
        .enter_pulse  (enter_pulse),
        .scroll_pulse (scroll_pulse),
        .cur_slot     (cur_slot),
        .wr_en        (wr_en),
        .wr_slot      (wr_slot),
        .wr_data      (wr_data),
        .setup_active (setup_active),
        .edit_pos     (edit_pos),
        .edit_value   (edit_value)
    );

    fou_slot_store #(.SEL_W(SEL_W)) u_store (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_slot (wr_slot),
        .wr_data (wr_data),
        .rd_slot (cur_slot),
        .rd_data (rd_data)
    );

    fou_apply #(.FREQ_W(FREQ_W)) u_apply (
        .clk            (clk),
        .rst            (rst),
        .hold           (setup_active),
        .freq_valid     (freq_valid),
        .freq_in        (freq_in),
        .offset         (rd_data),
        .freq_out       (freq_out),
        .freq_out_valid (freq_out_valid)
    );
endmodule

// File: rtl/fou_checker.sv
module fou_checker
    import fou_pkg::*;
#(
    parameter int FREQ_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              enter_pulse,
    input logic              scroll_pulse,
    input logic              freq_valid,
    input logic [FREQ_W-1:0] freq_out,
    input logic              freq_out_valid,
    input logic              setup_active,
    input logic [POS_W-1:0]  edit_pos,
    input logic [3:0]        edit_value
);
    p_sign_entry_r3: assert property (@(posedge clk) disable iff (rst)
        (!setup_active && enter_pulse) |=> (setup_active && edit_pos == '0 && edit_value == 4'd0));

    p_sign_toggle_r4: assert property (@(posedge clk) disable iff (rst)
        (setup_active && edit_pos == '0 && scroll_pulse && !enter_pulse)
        |=> (edit_value != $past(edit_value)));

    p_digit_range_r5: assert property (@(posedge clk) disable iff (rst)
        (setup_active && edit_pos != '0) |-> (edit_value <= 4'd9));

    p_digit_wrap_r5: assert property (@(posedge clk) disable iff (rst)
        (setup_active && edit_pos != '0 && scroll_pulse && !enter_pulse && edit_value == 4'd9)
        |=> (edit_value == 4'd0));

    p_exit_r6: assert property (@(posedge clk) disable iff (rst)
        (setup_active && edit_pos == POS_W'(LAST_POS) && enter_pulse) |=> !setup_active);

    p_result_pulse_r7: assert property (@(posedge clk) disable iff (rst)
        (!setup_active && freq_valid) |=> freq_out_valid);

    p_hold_in_setup_r9: assert property (@(posedge clk) disable iff (rst)
        setup_active |=> (!freq_out_valid && $stable(freq_out)));

    p_idle_scroll_r10: assert property (@(posedge clk) disable iff (rst)
        (!setup_active && scroll_pulse && !enter_pulse) |=> !setup_active);
endmodule

bind freq_offset_unit fou_checker #(.FREQ_W(FREQ_W)) u_chk (
    .clk            (clk),
    .rst            (rst),
    .enter_pulse    (enter_pulse),
    .scroll_pulse   (scroll_pulse),
    .freq_valid     (freq_valid),
    .freq_out       (freq_out),
    .freq_out_valid (freq_out_valid),
    .setup_active   (setup_active),
    .edit_pos       (edit_pos),
    .edit_value     (edit_value)
);

// File: tb/freq_offset_unit_bench.sv
`timescale 1ns/1ps
module freq_offset_unit_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        enter_pulse = 1'b0;
    logic        scroll_pulse = 1'b0;
    logic [3:0]  sel_n = 4'hF;
    logic [31:0] freq_in = '0;
    logic        freq_valid = 1'b0;
    logic [31:0] freq_out;
    logic        freq_out_valid;
    logic        setup_active;
    logic [2:0]  edit_pos;
    logic [3:0]  edit_value;

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    freq_offset_unit u_freq_offset_unit (
        .clk(clk), .rst(rst), .enter_pulse(enter_pulse), .scroll_pulse(scroll_pulse),
        .sel_n(sel_n), .freq_in(freq_in), .freq_valid(freq_valid),
        .freq_out(freq_out), .freq_out_valid(freq_out_valid),
        .setup_active(setup_active), .edit_pos(edit_pos), .edit_value(edit_value)
    );

    // Behavioural reference model
    int     m_mode;   // 0 normal, 1 sign, 2 digit
    int     m_field;
    int     m_val;
    int     m_neg;
    longint m_mag;
    int     m_target;
    longint m_ofs [16];
    longint m_out;
    bit     m_vld;

    always @(posedge clk) begin
        if (rst) begin
            m_mode = 0; m_field = 0; m_val = 0; m_neg = 0; m_mag = 0; m_target = 0;
            m_out = 0; m_vld = 0;
            foreach (m_ofs[i]) m_ofs[i] = 0;
        end else begin
            longint r;
            m_vld = 0;
            if (m_mode == 0 && freq_valid) begin
                r = longint'(freq_in) + m_ofs[int'(~sel_n)];
                if (r < 0) r = 0;
                if (r > 64'hFFFF_FFFF) r = 64'hFFFF_FFFF;
                m_out = r;
                m_vld = 1;
            end
            if (m_mode == 0) begin
                if (enter_pulse) begin
                    m_mode = 1; m_field = 0; m_val = 0; m_neg = 0; m_mag = 0;
                    m_target = int'(~sel_n);
                end
            end else if (m_mode == 1) begin
                if (enter_pulse) begin
                    m_mode = 2; m_field = 1; m_val = 0;
                end else if (scroll_pulse) begin
                    m_neg = 1 - m_neg;
                    m_val = m_neg;
                end
            end else begin
                if (enter_pulse) begin
                    m_mag = m_mag * 10 + m_val;
                    m_val = 0;
                    if (m_field == 7) begin
                        m_ofs[m_target] = (m_neg != 0) ? -(m_mag * 10) : m_mag * 10;
                        m_mode = 0; m_field = 0;
                    end else begin
                        m_field++;
                    end
                end else if (scroll_pulse) begin
                    m_val = (m_val + 1) % 10;
                end
            end
        end
    end

    task automatic check(input string req, input string what, input longint act, input longint exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (!rst && !done) begin
            check("R3", "setup_active", longint'(setup_active), longint'(m_mode != 0));
            check("R4", "edit_pos", longint'(edit_pos), longint'(m_field));
            check("R5", "edit_value", longint'(edit_value), longint'(m_val));
            check("R9", "freq_out_valid", longint'(freq_out_valid), longint'(m_vld));
            check("R7", "freq_out", longint'(freq_out), m_out);
        end
    end

    // Tasks start and end just after a falling edge.
    task automatic press(input bit ent, input bit scr);
        enter_pulse = ent; scroll_pulse = scr;
        @(negedge clk);
        enter_pulse = 1'b0; scroll_pulse = 1'b0;
    endtask

    task automatic measure(input logic [31:0] f, input string req, input longint exp);
        freq_in = f; freq_valid = 1'b1;
        @(negedge clk);
        freq_valid = 1'b0;
        check(req, "result strobe", longint'(freq_out_valid), 1);
        check(req, "corrected value", longint'(freq_out), exp);
    endtask

    task automatic enter_offset(input logic [3:0] sel, input int sign_steps, input int dig[7],
                                input logic [3:0] sel_mid);
        sel_n = sel;
        press(1'b1, 1'b0);
        sel_n = sel_mid;
        for (int k = 0; k < sign_steps; k++) press(1'b0, 1'b1);
        press(1'b1, 1'b0);
        for (int d = 0; d < 7; d++) begin
            for (int k = 0; k < dig[d]; k++) press(1'b0, 1'b1);
            press(1'b1, 1'b0);
        end
        sel_n = sel;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check("R1", "reset setup_active", longint'(setup_active), 0);
        check("R1", "reset freq_out", longint'(freq_out), 0);
        check("R1", "reset valid", longint'(freq_out_valid), 0);
        @(negedge clk);
        sel_n = 4'hF;
        measure(32'd5_000_000, "R1", 5_000_000);
        sel_n = 4'h0;
        measure(32'd7_000_000, "R1", 7_000_000);

        // R10: step alone in normal operation does nothing
        press(1'b0, 1'b1);
        check("R10", "idle step", longint'(setup_active), 0);

        // R2/R6/R7: slot 3 (sel_n 1100) +12340 Hz
        enter_offset(4'b1100, 2, '{0,0,0,1,2,3,4}, 4'b1100);
        check("R6", "setup cleared", longint'(setup_active), 0);
        sel_n = 4'b1100;
        measure(32'd5_000_000, "R7", 5_012_340);
        sel_n = 4'b1111;
        measure(32'd5_000_000, "R2", 5_000_000);

        // R4/R5/R8: slot 9 (sel_n 0110) -92,000,000 Hz, second digit wraps past 9
        enter_offset(4'b0110, 3, '{9,12,0,0,0,0,0}, 4'b0110);
        measure(32'd100_000_000, "R7", 8_000_000);
        measure(32'd50_000_000, "R8", 0);

        // R8: slot 15 (sel_n 0000) +99,999,990 saturates high
        enter_offset(4'b0000, 0, '{9,9,9,9,9,9,9}, 4'b0000);
        measure(32'hFFFF_0000, "R8", 64'hFFFF_FFFF);

        // R6: target latched at entry (slot 4), select moved to slot 6 during setup
        enter_offset(4'b1011, 0, '{0,0,0,0,0,0,5}, 4'b1001);
        sel_n = 4'b1001;
        measure(32'd1_000, "R6", 1_000);
        sel_n = 4'b1011;
        measure(32'd1_000, "R6", 1_050);

        // R9: strobe during setup is ignored; R10: both buttons together
        sel_n = 4'b1011;
        press(1'b1, 1'b0);
        freq_in = 32'd123; freq_valid = 1'b1;
        @(negedge clk);
        freq_valid = 1'b0;
        check("R9", "strobe in setup", longint'(freq_out_valid), 0);
        check("R9", "value held", longint'(freq_out), 1_050);
        press(1'b1, 1'b1);
        check("R10", "both buttons pos", longint'(edit_pos), 1);
        check("R10", "both buttons value", longint'(edit_value), 0);
        for (int d = 0; d < 7; d++) press(1'b1, 1'b0);
        check("R3", "slot 4 rewritten to +0 exit", longint'(setup_active), 0);
        measure(32'd1_000, "R3", 1_000);

        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            tests++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule